// File: doc/BRIEF.md
# Page table walker

This block turns an input address into an output address by reading a chain of 64-bit translation descriptors from memory, starting at the root table named by a per-context base register. A walk begins with a one-cycle start strobe that captures the address, the access direction and the context settings: table base, input-size field, granule size and the hierarchical-permission disable bit. The walker then reads one descriptor at a time through a request/response port.

Each descriptor read is classified as unusable, a pointer to a next-level table, or a leaf mapping (a block above level 3, a page at level 3). Table pointers are followed down one level. A leaf ends the walk with a result record that a translation cache can store unchanged: the leaf's output base, the input address aligned to the leaf size, the size mask, read/write permissions, the level where the leaf was found and the granule shift. Unusable descriptors and permission violations end the walk with a fault record whose permissions are empty.

Top module: `page_walker`

## Requirements
- R1: The granule code selects the page shift: 1 gives 14, 2 gives 16, 0 or 3 gives 12. With stride = shift − 3, input size = 64 − cfg_tsz and levels numbered 0 to 3, the walk starts at level 4 − (input size − 4)/stride, clamped to 0..3. The shift for level L is page shift + (3 − L)·stride. The root base is cfg_ttb with its low (input size − start-level shift + 3) bits cleared. Each descriptor address is the current base plus 8 × (walk_va shifted right by the level shift, keeping stride bits).
- R2: A descriptor with bit 0 clear is unusable. At level 3, bit 1 clear is unusable. At level 0, bit 1 clear (a block) is unusable. An unusable descriptor ends the walk with fault_kind 0 (translation).
- R3: Below level 3, a descriptor with bits 1:0 = 11 is a table. The next base is its bits ADDR_W−1..0 with the low page-shift bits cleared, and the walk reads the next level.
- R4: A write walk that meets a table descriptor with bit 62 set ends with fault_kind 1 (permission), unless cfg_hdis was set at start. In that case bit 62 is ignored.
- R5: A leaf with bit 7 set is read-only. A write walk that reaches it ends with fault_kind 1. A read walk always passes.
- R6: On success, res_mask = 2^(level shift) − 1, res_va = walk_va with the mask bits cleared, res_pa = the leaf's bits ADDR_W−1..0 with the mask bits cleared, res_level = leaf level and res_gshift = page shift. res_perm bit 0 (read) is 1 and bit 1 (write) is the inverse of leaf bit 7.
- R7: On any fault, fault is 1 and res_perm is 0.
- R8: mem_req is a one-cycle pulse, with at most one read outstanding. busy rises in the cycle after the start strobe. done is a one-cycle pulse in the cycle after the final response, and busy drops in the following cycle. The number of reads equals the number of levels visited.
- R9: A start strobe while busy is ignored. It changes neither the current walk nor the state after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| walk_start | input | 1 | Start strobe, taken only when idle |
| walk_va | input | ADDR_W | Address to translate |
| walk_write | input | 1 | 1 for a write access |
| cfg_ttb | input | ADDR_W | Root table base |
| cfg_tsz | input | 6 | Input-size field (input size = 64 − value) |
| cfg_gran | input | 2 | Granule code |
| cfg_hdis | input | 1 | Skip the table-level permission check |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Descriptor read request pulse |
| mem_addr | output | ADDR_W | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 64 | Descriptor data |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Walk ended in a fault |
| fault_kind | output | 1 | 0 translation, 1 permission |
| res_pa | output | ADDR_W | Leaf output base |
| res_va | output | ADDR_W | Aligned input address |
| res_mask | output | ADDR_W | Leaf size mask |
| res_perm | output | 2 | {write, read} permission |
| res_level | output | 2 | Level of the leaf or fault |
| res_gshift | output | 5 | Page shift of the walk |

## Verification
A corrupted level counter or base register shows up on mem_addr at the next read request, one or two cycles after the previous response. It also shows up later as a wrong res_level, res_mask or res_pa at done. A wrong state decode shows at once as mem_req or done lasting more than one cycle, or as a read issued while another is outstanding. A corrupted permission decision shows only at done, as a fault where a result was expected or the reverse. Random multi-level walks are therefore compared field by field against an independent walk over the same memory contents.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } walk_state_e;

  typedef enum logic [1:0] {
    DK_BAD   = 2'd0,
    DK_TABLE = 2'd1,
    DK_LEAF  = 2'd2
  } desc_kind_e;

  localparam int DESC_W      = 64;
  localparam int BIT_VALID   = 0;
  localparam int BIT_TYPE    = 1;
  localparam int BIT_LEAF_RO = 7;
  localparam int BIT_TBL_RO  = 62;

  localparam logic FK_TRANSLATION = 1'b0;
  localparam logic FK_PERMISSION  = 1'b1;

  function automatic logic [4:0] gran_shift(input logic [1:0] code);
    case (code)
      2'd1:    return 5'd14;
      2'd2:    return 5'd16;
      default: return 5'd12;
    endcase
  endfunction

  function automatic logic [5:0] level_shift(input logic [4:0] gs, input logic [1:0] lv);
    int r;
    r = int'(gs) + (3 - int'(lv)) * (int'(gs) - 3);
    return 6'(r);
  endfunction

  function automatic logic [63:0] low_mask(input logic [6:0] n);
    return (64'd1 << n) - 64'd1;
  endfunction

  function automatic logic [1:0] start_level(input logic [4:0] gs, input logic [5:0] tsz);
    int insz;
    int q;
    insz = 64 - int'(tsz);
    case (gs)
      5'd14:   q = (insz - 4) / 11;
      5'd16:   q = (insz - 4) / 13;
      default: q = (insz - 4) / 9;
    endcase
    if (q >= 4) return 2'd0;
    if (q <= 1) return 2'd3;
    return 2'(4 - q);
  endfunction

endpackage

// File: rtl/ptw_desc_class.sv
module ptw_desc_class
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic [DESC_W-1:0] desc,
  input  logic [1:0]        level,
  input  logic [4:0]        gshift,
  input  logic              is_write,
  input  logic              hdis,
  output desc_kind_e        kind,
  output logic              perm_ok,
  output logic [ADDR_W-1:0] next_base,
  output logic [ADDR_W-1:0] leaf_base,
  output logic [ADDR_W-1:0] leaf_mask,
  output logic [1:0]        leaf_perm
);

  logic [63:0] gmask;
  logic [63:0] lmask;

  assign gmask = low_mask({2'b00, gshift});
  assign lmask = low_mask({1'b0, level_shift(gshift, level)});

  always_comb begin
    if (!desc[BIT_VALID])           kind = DK_BAD;
    else if (level == 2'd3)         kind = desc[BIT_TYPE] ? DK_LEAF : DK_BAD;
    else if (desc[BIT_TYPE])        kind = DK_TABLE;
    else if (level == 2'd0)         kind = DK_BAD;
    else                            kind = DK_LEAF;
  end

  always_comb begin
    if (kind == DK_TABLE)
      perm_ok = !(is_write && desc[BIT_TBL_RO] && !hdis);
    else
      perm_ok = !(is_write && desc[BIT_LEAF_RO]);
  end

  assign next_base = ADDR_W'(desc & ~gmask);
  assign leaf_base = ADDR_W'(desc & ~lmask);
  assign leaf_mask = ADDR_W'(lmask);
  assign leaf_perm = {~desc[BIT_LEAF_RO], 1'b1};

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] va,
  input  logic [1:0]        level,
  input  logic [4:0]        gshift,
  output logic [ADDR_W-1:0] desc_addr
);

  localparam int PAD_W = 64 - ADDR_W;

  logic [5:0]  shamt;
  logic [63:0] idx;

  assign shamt     = level_shift(gshift, level);
  assign idx       = ({{PAD_W{1'b0}}, va} >> shamt) & low_mask({2'b00, gshift} - 7'd3);
  assign desc_addr = base + ADDR_W'(idx << 3);

endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              walk_start,
  input  logic [ADDR_W-1:0] walk_va,
  input  logic              walk_write,
  input  logic [ADDR_W-1:0] cfg_ttb,
  input  logic [5:0]        cfg_tsz,
  input  logic [1:0]        cfg_gran,
  input  logic              cfg_hdis,
  input  logic              mem_rsp_valid,
  input  desc_kind_e        dkind,
  input  logic              perm_ok,
  input  logic [ADDR_W-1:0] next_base,
  input  logic [ADDR_W-1:0] leaf_base,
  input  logic [ADDR_W-1:0] leaf_mask,
  input  logic [1:0]        leaf_perm,
  output logic [ADDR_W-1:0] cur_base,
  output logic [ADDR_W-1:0] cur_va,
  output logic [1:0]        cur_level,
  output logic [4:0]        cur_gshift,
  output logic              cur_write,
  output logic              cur_hdis,
  output logic              busy,
  output logic              mem_req,
  output logic              done,
  output logic              fault,
  output logic              fault_kind,
  output logic [ADDR_W-1:0] res_pa,
  output logic [ADDR_W-1:0] res_va,
  output logic [ADDR_W-1:0] res_mask,
  output logic [1:0]        res_perm,
  output logic [1:0]        res_level
);

  walk_state_e state_q, state_d;

  logic              cfg_en, step_en, res_en;
  logic [4:0]        gs_start;
  logic [1:0]        lv_start;
  logic [ADDR_W-1:0] root_base;
  logic [ADDR_W-1:0] base_q, base_d, va_q;
  logic [1:0]        level_q, level_d;
  logic [4:0]        gs_q;
  logic              wr_q, hdis_q;
  logic              fault_q, fault_d, fkind_q, fkind_d;
  logic [ADDR_W-1:0] pa_q, pa_d, rva_q, rva_d, mask_q, mask_d;
  logic [1:0]        perm_q, perm_d;

  // root table geometry from the context settings
  always_comb begin
    int tb;
    gs_start = gran_shift(cfg_gran);
    lv_start = start_level(gs_start, cfg_tsz);
    tb = 64 - int'(cfg_tsz) - int'(level_shift(gs_start, lv_start));
    if (tb < 0) tb = 0;
    root_base = cfg_ttb & ~ADDR_W'(low_mask(7'(tb + 3)));
  end

  always_comb begin
    state_d = state_q;
    cfg_en  = 1'b0;
    step_en = 1'b0;
    res_en  = 1'b0;
    base_d  = next_base;
    level_d = level_q + 2'd1;
    fault_d = 1'b1;
    fkind_d = FK_TRANSLATION;
    perm_d  = 2'b00;
    pa_d    = '0;
    rva_d   = '0;
    mask_d  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (walk_start) begin
          cfg_en  = 1'b1;
          base_d  = root_base;
          level_d = lv_start;
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          unique case (dkind)
            DK_TABLE: begin
              if (perm_ok) begin
                step_en = 1'b1;
                state_d = ST_ISSUE;
              end else begin
                res_en  = 1'b1;
                fkind_d = FK_PERMISSION;
                state_d = ST_FIN;
              end
            end
            DK_LEAF: begin
              res_en  = 1'b1;
              state_d = ST_FIN;
              if (perm_ok) begin
                fault_d = 1'b0;
                perm_d  = leaf_perm;
                pa_d    = leaf_base;
                rva_d   = va_q & ~leaf_mask;
                mask_d  = leaf_mask;
              end else begin
                fkind_d = FK_PERMISSION;
              end
            end
            default: begin
              res_en  = 1'b1;
              state_d = ST_FIN;
            end
          endcase
        end
      end
      ST_FIN: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      va_q    <= '0;
      level_q <= '0;
      gs_q    <= 5'd12;
      wr_q    <= 1'b0;
      hdis_q  <= 1'b0;
      fault_q <= 1'b0;
      fkind_q <= 1'b0;
      pa_q    <= '0;
      rva_q   <= '0;
      mask_q  <= '0;
      perm_q  <= '0;
    end else begin
      state_q <= state_d;
      if (cfg_en) begin
        va_q   <= walk_va;
        wr_q   <= walk_write;
        hdis_q <= cfg_hdis;
        gs_q   <= gs_start;
      end
      if (cfg_en || step_en) begin
        base_q  <= base_d;
        level_q <= level_d;
      end
      if (res_en) begin
        fault_q <= fault_d;
        fkind_q <= fkind_d;
        pa_q    <= pa_d;
        rva_q   <= rva_d;
        mask_q  <= mask_d;
        perm_q  <= perm_d;
      end
    end
  end

  assign cur_base   = base_q;
  assign cur_va     = va_q;
  assign cur_level  = level_q;
  assign cur_gshift = gs_q;
  assign cur_write  = wr_q;
  assign cur_hdis   = hdis_q;
  assign busy       = (state_q != ST_IDLE);
  assign mem_req    = (state_q == ST_ISSUE);
  assign done       = (state_q == ST_FIN);
  assign fault      = fault_q;
  assign fault_kind = fkind_q;
  assign res_pa     = pa_q;
  assign res_va     = rva_q;
  assign res_mask   = mask_q;
  assign res_perm   = perm_q;
  assign res_level  = level_q;

endmodule

// File: rtl/page_walker.sv
module page_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              walk_start,
  input  logic [ADDR_W-1:0] walk_va,
  input  logic              walk_write,
  input  logic [ADDR_W-1:0] cfg_ttb,
  input  logic [5:0]        cfg_tsz,
  input  logic [1:0]        cfg_gran,
  input  logic              cfg_hdis,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic              fault_kind,
  output logic [ADDR_W-1:0] res_pa,
  output logic [ADDR_W-1:0] res_va,
  output logic [ADDR_W-1:0] res_mask,
  output logic [1:0]        res_perm,
  output logic [1:0]        res_level,
  output logic [4:0]        res_gshift
);

  desc_kind_e        dkind;
  logic              perm_ok;
  logic [ADDR_W-1:0] next_base, leaf_base, leaf_mask;
  logic [1:0]        leaf_perm;
  logic [ADDR_W-1:0] cur_base, cur_va;
  logic [1:0]        cur_level;
  logic [4:0]        cur_gshift;
  logic              cur_write, cur_hdis;

  ptw_walk_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .walk_start(walk_start), .walk_va(walk_va), .walk_write(walk_write),
    .cfg_ttb(cfg_ttb), .cfg_tsz(cfg_tsz), .cfg_gran(cfg_gran), .cfg_hdis(cfg_hdis),
    .mem_rsp_valid(mem_rsp_valid),
    .dkind(dkind), .perm_ok(perm_ok), .next_base(next_base),
    .leaf_base(leaf_base), .leaf_mask(leaf_mask), .leaf_perm(leaf_perm),
    .cur_base(cur_base), .cur_va(cur_va), .cur_level(cur_level),
    .cur_gshift(cur_gshift), .cur_write(cur_write), .cur_hdis(cur_hdis),
    .busy(busy), .mem_req(mem_req), .done(done),
    .fault(fault), .fault_kind(fault_kind),
    .res_pa(res_pa), .res_va(res_va), .res_mask(res_mask),
    .res_perm(res_perm), .res_level(res_level)
  );

  ptw_addr_gen #(.ADDR_W(ADDR_W)) addr_i (
    .base(cur_base), .va(cur_va), .level(cur_level),
    .gshift(cur_gshift), .desc_addr(mem_addr)
  );

  ptw_desc_class #(.ADDR_W(ADDR_W)) class_i (
    .desc(mem_rsp_data), .level(cur_level), .gshift(cur_gshift),
    .is_write(cur_write), .hdis(cur_hdis),
    .kind(dkind), .perm_ok(perm_ok), .next_base(next_base),
    .leaf_base(leaf_base), .leaf_mask(leaf_mask), .leaf_perm(leaf_perm)
  );

  assign res_gshift = cur_gshift;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rsp_valid,
  input logic              done,
  input logic              fault,
  input logic [ADDR_W-1:0] res_pa,
  input logic [ADDR_W-1:0] res_va,
  input logic [ADDR_W-1:0] res_mask,
  input logic [1:0]        res_perm
);

  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pend_q <= 1'b0;
    else if (mem_req)       pend_q <= 1'b1;
    else if (mem_rsp_valid) pend_q <= 1'b0;
  end

  a_r1_req_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[2:0] == 3'b000));

  a_r8_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !pend_q);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r8_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_rsp_valid));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !done));

  a_r7_fault_no_perm: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (res_perm == 2'b00));

  a_r6_read_perm: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> res_perm[0]);

  a_r6_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> ((((res_mask + 1'b1) & res_mask) == '0) &&
                          ((res_va & res_mask) == '0) &&
                          ((res_pa & res_mask) == '0)));

endmodule

bind page_walker ptw_checker #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/page_walker_tb_top.sv
module page_walker_tb_top;

  localparam int AW = 48;
  localparam logic [63:0] M48 = 64'h0000_FFFF_FFFF_FFFF;

  logic          clk, rst_n;
  logic          walk_start, walk_write, cfg_hdis;
  logic [AW-1:0] walk_va, cfg_ttb;
  logic [5:0]    cfg_tsz;
  logic [1:0]    cfg_gran;
  logic          busy, mem_req, mem_rsp_valid, done, fault, fault_kind;
  logic [AW-1:0] mem_addr, res_pa, res_va, res_mask;
  logic [63:0]   mem_rsp_data;
  logic [1:0]    res_perm, res_level;
  logic [4:0]    res_gshift;

  int nchk = 0;
  int nfail = 0;
  int req_seen = 0;

  logic [63:0] mem_m [logic [63:0]];

  page_walker #(.ADDR_W(AW)) dut_i (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // memory responder: one read at a time, 1 to 3 cycles after the request
  initial begin
    bit pending;
    int delay;
    logic [63:0] a;
    pending = 0;
    delay = 0;
    a = '0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      if (pending) begin
        if (delay == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = mem_m.exists(a) ? mem_m[a] : 64'd0;
          pending = 0;
        end else delay--;
      end else if (mem_req) begin
        req_seen++;
        a = {16'd0, mem_addr};
        pending = 1;
        delay = $urandom_range(0, 2);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int gshift_of(input int gran);
    return (gran == 1) ? 14 : (gran == 2) ? 16 : 12;
  endfunction

  function automatic int first_level(input int gs, input int tsz);
    int q;
    q = (64 - tsz - 4) / (gs - 3);
    if (q >= 4) return 0;
    if (q <= 1) return 3;
    return 4 - q;
  endfunction

  function automatic int lsh(input int gs, input int l);
    return gs + (3 - l) * (gs - 3);
  endfunction

  function automatic logic [63:0] root_of(input logic [63:0] ttb, input int gs, input int tsz);
    int st;
    int tb;
    st = first_level(gs, tsz);
    tb = 64 - tsz - lsh(gs, st);
    if (tb < 0) tb = 0;
    return ttb & M48 & ~((64'd1 << (tb + 3)) - 64'd1);
  endfunction

  function automatic logic [63:0] daddr(input logic [63:0] base, input logic [63:0] va, input int gs, input int l);
    return (base + ((((va >> lsh(gs, l)) & ((64'd1 << (gs - 3)) - 64'd1))) << 3)) & M48;
  endfunction

  // independent model of the walk
  function automatic void ref_walk(input logic [63:0] va, input bit wr, input logic [63:0] ttb,
      input int tsz, input int gran, input bit hdis,
      output bit f, output bit fk, output logic [63:0] pa, output logic [63:0] rva,
      output logic [63:0] mask, output int perm, output int lvl, output int nreads);
    int gs;
    logic [63:0] base, d, a;
    gs = gshift_of(gran);
    base = root_of(ttb, gs, tsz);
    f = 1; fk = 0; pa = 0; rva = 0; mask = 0; perm = 0; lvl = 0; nreads = 0;
    for (int l = first_level(gs, tsz); l <= 3; l++) begin
      nreads++;
      lvl = l;
      a = daddr(base, va, gs, l);
      d = mem_m.exists(a) ? mem_m[a] : 64'd0;
      if (!d[0] || (!d[1] && (l == 3 || l == 0))) begin
        fk = 0; return;
      end
      if (l < 3 && d[1]) begin
        if (wr && d[62] && !hdis) begin fk = 1; return; end
        base = d & M48 & ~((64'd1 << gs) - 64'd1);
      end else begin
        if (wr && d[7]) begin fk = 1; return; end
        mask = (64'd1 << lsh(gs, l)) - 64'd1;
        f = 0;
        pa = d & M48 & ~mask;
        rva = va & ~mask;
        perm = d[7] ? 1 : 3;
        return;
      end
    end
  endfunction

  task automatic build(input logic [63:0] va, input logic [63:0] ttb, input int tsz, input int gran,
      input int leaf_lvl, input logic [63:0] pa, input bit ro, input logic [3:0] tro,
      input int bad_lvl, input logic [63:0] bad_desc);
    int gs;
    logic [63:0] base, a, nb, mask;
    gs = gshift_of(gran);
    base = root_of(ttb, gs, tsz);
    mem_m.delete();
    for (int l = first_level(gs, tsz); l <= 3; l++) begin
      a = daddr(base, va, gs, l);
      if (l == bad_lvl) begin
        mem_m[a] = bad_desc;
        return;
      end
      if (l < leaf_lvl) begin
        nb = 64'h8000_0000 + 64'(l) * 64'h100_0000 + (64'($urandom_range(0, 15)) << 16);
        mem_m[a] = nb | 64'd3 | (64'(tro[l]) << 62);
        base = nb;
      end else begin
        mask = (64'd1 << lsh(gs, l)) - 64'd1;
        mem_m[a] = (pa & M48 & ~mask) | ((l == 3) ? 64'd3 : 64'd1) | (64'(ro) << 7);
        return;
      end
    end
  endtask

  task automatic walk(input string req, input logic [63:0] va, input bit wr, input logic [63:0] ttb,
      input int tsz, input int gran, input bit hdis, input bit poke);
    bit f, fk;
    logic [63:0] pa, rva, mask;
    int perm, lvl, nr, t;
    ref_walk(va, wr, ttb, tsz, gran, hdis, f, fk, pa, rva, mask, perm, lvl, nr);
    @(negedge clk);
    walk_va = va[AW-1:0]; walk_write = wr; cfg_ttb = ttb[AW-1:0];
    cfg_tsz = 6'(tsz); cfg_gran = 2'(gran); cfg_hdis = hdis;
    req_seen = 0;
    walk_start = 1'b1;
    @(negedge clk);
    walk_start = 1'b0;
    chk("R8", "busy after start", 64'(busy), 64'd1);
    if (poke) begin
      walk_start = 1'b1; walk_va = ~va[AW-1:0]; walk_write = ~wr; cfg_hdis = ~hdis;
      @(negedge clk);
      walk_start = 1'b0;
    end
    t = 0;
    while (!done && t < 400) begin @(negedge clk); t++; end
    if (!done) begin
      nfail++;
      $display("FAIL %s walk timeout: actual no done expected done", req);
      return;
    end
    chk(req, "fault", 64'(fault), 64'(f));
    if (f) begin
      chk(req, "fault_kind", 64'(fault_kind), 64'(fk));
      chk("R7", "perm on fault", 64'(res_perm), 64'd0);
    end else begin
      chk("R6", "res_pa", 64'(res_pa), pa);
      chk("R6", "res_va", 64'(res_va), rva);
      chk("R6", "res_mask", 64'(res_mask), mask);
      chk("R6", "res_perm", 64'(res_perm), 64'(perm));
      chk("R6", "res_level", 64'(res_level), 64'(lvl));
      chk("R1", "res_gshift", 64'(res_gshift), 64'(gshift_of(gran)));
    end
    chk("R8", "read count", 64'(req_seen), 64'(nr));
    @(negedge clk);
    chk("R8", "busy after done", 64'(busy), 64'd0);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk("R9", "no restart", 64'({busy, mem_req}), 64'd0);
    end
  endtask

  initial begin
    logic [63:0] va, ttb, pa;
    int gran, tsz, st, leaf, bad;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    walk_start = 1'b0; walk_write = 1'b0; cfg_hdis = 1'b0;
    walk_va = '0; cfg_ttb = '0; cfg_tsz = 6'd16; cfg_gran = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "reset busy/req/done", 64'({busy, mem_req, done}), 64'd0);

    ttb = 64'h4000_3000;
    va  = 64'h0000_7A5B_3C4D_5E6F & M48;
    pa  = 64'h0000_1234_5678_9000;
    // R1 R3 four-level 4KB walk to a page
    build(va, ttb, 16, 0, 3, pa, 0, 4'b0000, -1, 0);
    walk("R1", va, 0, ttb, 16, 0, 0, 0);
    walk("R3", va, 1, ttb, 16, 0, 0, 0);
    // R5 read-only leaf: read passes, write faults
    build(va, ttb, 16, 0, 3, pa, 1, 4'b0000, -1, 0);
    walk("R5", va, 0, ttb, 16, 0, 0, 0);
    walk("R5", va, 1, ttb, 16, 0, 0, 0);
    // R4 read-only table at level 1, with and without the disable bit
    build(va, ttb, 16, 0, 3, pa, 0, 4'b0010, -1, 0);
    walk("R4", va, 1, ttb, 16, 0, 0, 0);
    walk("R4", va, 1, ttb, 16, 0, 1, 0);
    walk("R4", va, 0, ttb, 16, 0, 0, 0);
    // R2 invalid at level 2, type-clear at level 3, block at level 0
    build(va, ttb, 16, 0, 3, pa, 0, 4'b0000, 2, 64'h0000_0000_0010_0002);
    walk("R2", va, 0, ttb, 16, 0, 0, 0);
    build(va, ttb, 16, 0, 3, pa, 0, 4'b0000, 3, 64'h0000_0000_0020_0001);
    walk("R2", va, 0, ttb, 16, 0, 0, 0);
    build(va, ttb, 16, 0, 0, pa, 0, 4'b0000, -1, 0);
    walk("R2", va, 0, ttb, 16, 0, 0, 0);
    // R6 2MB block at level 2
    build(va, ttb, 16, 0, 2, pa, 0, 4'b0000, -1, 0);
    walk("R6", va, 0, ttb, 16, 0, 0, 0);
    // R1 64KB granule starting at level 2, 16KB granule block at level 2
    va = 64'h0000_0123_4567_89AB & ((64'd1 << 42) - 1);
    build(va, ttb, 22, 2, 3, pa, 0, 4'b0000, -1, 0);
    walk("R1", va, 0, ttb, 22, 2, 0, 0);
    va = 64'h0000_0009_8765_4321;
    build(va, ttb, 28, 1, 2, pa, 0, 4'b0000, -1, 0);
    walk("R1", va, 0, ttb, 28, 1, 0, 0);
    // R9 start strobe while busy
    va = 64'h0000_1111_2222_3000;
    build(va, ttb, 16, 0, 3, pa, 0, 4'b0000, -1, 0);
    walk("R9", va, 0, ttb, 16, 0, 0, 1);

    for (int i = 0; i < 80; i++) begin
      gran = $urandom_range(0, 2);
      case (gran)
        0: tsz = (i % 3 == 0) ? 16 : (i % 3 == 1) ? 25 : 34;
        1: tsz = (i % 3 == 0) ? 16 : (i % 3 == 1) ? 20 : 28;
        default: tsz = (i % 2 == 0) ? 16 : 22;
      endcase
      st = first_level(gshift_of(gran), tsz);
      leaf = $urandom_range(st, 3);
      bad = ($urandom_range(0, 3) == 0) ? $urandom_range(st, 3) : -1;
      va = {$urandom, $urandom} & ((64'd1 << (64 - tsz)) - 1) & M48;
      pa = {$urandom, $urandom} & M48;
      ttb = (64'h4000_0000 | (64'($urandom_range(0, 255)) << 12)) | 64'($urandom_range(0, 7));
      build(va, ttb, tsz, gran, leaf, pa, 1'($urandom), 4'($urandom), bad,
            {32'd0, $urandom} & 64'hFFFF_FFFE);
      walk("R6", va, 1'($urandom), ttb, tsz, gran, 1'($urandom), (i % 10) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule